// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block sits beside the shared bus of a four-node multiprocessor and tracks which nodes may be caching each line. It holds a set-associative table of line tags. Every entry carries an owner bitmap with one bit per node. A coherent request looks up its line and gets back, in the same cycle, the set of other nodes that need a snoop. Nodes that cannot hold the line are never disturbed.

The owner bits change as lines are filled and written. Nodes report their own evictions on a separate notify port, and those notices clear bits as well. When a new line maps to a set whose ways are all in use, the filter chooses an entry to give up. It picks the entry with the fewest owners and breaks ties by age. It then raises a back-invalidate naming that entry's line and owners. The request is held until the back-invalidate is acknowledged.

Top module: `snoop_filter`

## Requirements
- R1: After reset every entry is invalid: `req_ready` is 1, `binv_valid` is 0, and a first request to any line gets an empty `snoop_mask`.
- R2: A read by node n that hits returns in `snoop_mask` the owner bitmap without bit n, where bit k stands for node k. It then adds bit n to the bitmap.
- R3: A write by node n returns every owner other than n as the snoop targets and leaves only bit n in the bitmap. A write that misses returns an empty mask.
- R4: A line address is split into a set index (its low log2(SETS) bits) and a tag (the remaining high bits). A miss takes the lowest-numbered invalid way of its set, and no back-invalidate is raised while any way is invalid.
- R5: A miss into a set with every way valid raises `binv_valid`, with `binv_line` and `binv_mask` set to the line and owner bitmap of the victim. The victim is the valid entry whose bitmap has the fewest set bits.
- R6: Among entries that tie on the fewest owners, the one used least recently is the victim.
- R7: While `binv_valid` is high and `binv_ack` is low, `req_ready` stays low and the table is unchanged. The new line is installed in the victim's way in the cycle the acknowledgement arrives.
- R8: An eviction notice from node n clears bit n of a matching entry. An entry whose bitmap becomes all zero turns invalid and frees its way.
- R9: Every hit and every allocation makes that way the most recently used in its set. Eviction notices leave the recency order untouched.
- R10: An eviction notice takes precedence over a request in the same cycle: `req_ready` is low in that cycle, and the request then sees the table after the notice has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Coherent request present |
| req_node | input | 2 | Requesting node |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 12 | Line address of the request |
| req_ready | output | 1 | Request accepted at this clock edge |
| snoop_mask | output | 4 | Nodes to snoop for this request |
| evn_valid | input | 1 | Eviction notice present |
| evn_node | input | 2 | Node that dropped the line |
| evn_line | input | 12 | Line address dropped |
| binv_valid | output | 1 | Back-invalidate pending |
| binv_line | output | 12 | Line address of the victim |
| binv_mask | output | 4 | Owners of the victim |
| binv_ack | input | 1 | Back-invalidate acknowledged |

## Verification
The hardest case to reach from the ports is victim selection when owner count and age interact. The bench needs a full set in which two entries tie on the fewest owners and neither is the oldest entry overall. It builds that pattern through a chosen order of reads by different nodes, so the expected victim follows from popcount first and recency second. A second set is filled with single-owner lines, and then its oldest line is hit again. This shows that a hit alone shifts the victim to the next-oldest line. The back-invalidate is held unacknowledged for an extra cycle to show the stall.

// File: rtl/sf_pkg.sv
package sf_pkg;
    localparam int NODES  = 4;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int LINE_W = 12;

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = LINE_W - IDX_W;
    localparam int NODE_W = $clog2(NODES);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int AGE_W  = $clog2(WAYS);
    localparam int CNT_W  = $clog2(NODES + 1);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [NODES-1:0] owners;
        logic [AGE_W-1:0] age;   // 0 = most recent, WAYS-1 = oldest
    } sf_entry_t;

    typedef sf_entry_t [WAYS-1:0] sf_row_t;

    function automatic logic [CNT_W-1:0] owner_count(input logic [NODES-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NODES; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction
endpackage

// File: rtl/sf_lookup.sv
module sf_lookup
    import sf_pkg::*;
(
    input  sf_row_t           row,
    input  logic [TAG_W-1:0]  tag,
    output logic [WAYS-1:0]   hit_vec,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic              free,
    output logic [WAY_W-1:0]  free_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row[w].valid && (row[w].tag == tag);
    end

    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        free     = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!row[w].valid) begin
                free     = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/sf_victim.sv
module sf_victim
    import sf_pkg::*;
(
    input  sf_row_t          row,
    output logic [WAY_W-1:0] victim_way
);
    logic [CNT_W-1:0] cnt [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_cnt
        assign cnt[w] = owner_count(row[w].owners);
    end

    always_comb begin
        victim_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (cnt[w] < cnt[victim_way] ||
                (cnt[w] == cnt[victim_way] && row[w].age > row[victim_way].age))
                victim_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
    import sf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [NODE_W-1:0]   req_node,
    input  logic                req_write,
    input  logic [LINE_W-1:0]   req_line,
    output logic                req_ready,
    output logic [NODES-1:0]    snoop_mask,
    input  logic                evn_valid,
    input  logic [NODE_W-1:0]   evn_node,
    input  logic [LINE_W-1:0]   evn_line,
    output logic                binv_valid,
    output logic [LINE_W-1:0]   binv_line,
    output logic [NODES-1:0]    binv_mask,
    input  logic                binv_ack
);
    sf_row_t tbl_q [SETS];

    // request side lookup
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    sf_row_t          r_row;
    logic [WAYS-1:0]  r_hits;
    logic             r_hit, r_free;
    logic [WAY_W-1:0] r_hit_way, r_free_way, r_vic_way, r_tgt;
    logic [NODES-1:0] r_self, r_new_owners;
    logic             need_victim, req_fire;
    sf_row_t          r_next;

    assign r_idx  = req_line[IDX_W-1:0];
    assign r_tag  = req_line[LINE_W-1:IDX_W];
    assign r_row  = tbl_q[r_idx];
    assign r_self = NODES'(1) << req_node;

    sf_lookup u_req_lookup (
        .row(r_row), .tag(r_tag), .hit_vec(r_hits), .hit(r_hit),
        .hit_way(r_hit_way), .free(r_free), .free_way(r_free_way)
    );

    sf_victim u_victim (.row(r_row), .victim_way(r_vic_way));

    assign need_victim = req_valid && !r_hit && !r_free;
    assign binv_valid  = need_victim && !evn_valid;
    assign binv_line   = {r_row[r_vic_way].tag, r_idx};
    assign binv_mask   = r_row[r_vic_way].owners;
    assign req_ready   = !evn_valid && (!need_victim || binv_ack);
    assign req_fire    = req_valid && req_ready;
    assign snoop_mask  = (req_valid && r_hit) ? (r_row[r_hit_way].owners & ~r_self) : '0;

    always_comb begin
        r_tgt = r_hit ? r_hit_way : (r_free ? r_free_way : r_vic_way);
        if (r_hit && !req_write) r_new_owners = r_row[r_hit_way].owners | r_self;
        else                     r_new_owners = r_self;
        r_next = r_row;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == r_tgt)                  r_next[w].age = '0;
            else if (r_row[w].age < r_row[r_tgt].age) r_next[w].age = r_row[w].age + 1'b1;
        end
        r_next[r_tgt].valid  = 1'b1;
        r_next[r_tgt].tag    = r_tag;
        r_next[r_tgt].owners = r_new_owners;
    end

    // eviction notice side lookup
    logic [IDX_W-1:0] e_idx;
    logic [TAG_W-1:0] e_tag;
    sf_row_t          e_row;
    logic [WAYS-1:0]  e_hits;
    logic             e_hit, e_free;
    logic [WAY_W-1:0] e_hit_way, e_free_way;
    logic [NODES-1:0] e_left;

    assign e_idx  = evn_line[IDX_W-1:0];
    assign e_tag  = evn_line[LINE_W-1:IDX_W];
    assign e_row  = tbl_q[e_idx];
    assign e_left = e_row[e_hit_way].owners & ~(NODES'(1) << evn_node);

    sf_lookup u_evn_lookup (
        .row(e_row), .tag(e_tag), .hit_vec(e_hits), .hit(e_hit),
        .hit_way(e_hit_way), .free(e_free), .free_way(e_free_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tbl_q[s][w] <= '{valid: 1'b0, tag: '0, owners: '0, age: AGE_W'(w)};
        end else if (evn_valid) begin
            if (e_hit) begin
                tbl_q[e_idx][e_hit_way].owners <= e_left;
                if (e_left == '0) tbl_q[e_idx][e_hit_way].valid <= 1'b0;
            end
        end else if (req_fire) begin
            tbl_q[r_idx] <= r_next;
        end
    end

    // assertions
    logic [WAYS-1:0] r_age_seen;
    logic            r_owned_ok;
    always_comb begin
        r_age_seen = '0;
        r_owned_ok = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            r_age_seen = r_age_seen | (WAYS'(1) << r_row[w].age);
            if (r_row[w].valid && r_row[w].owners == '0) r_owned_ok = 1'b0;
        end
    end

    p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot0(r_hits));
    p_victim_owned_r5: assert property (@(posedge clk) disable iff (rst)
        binv_valid |-> (binv_mask != '0));
    p_stall_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (binv_valid && !binv_ack) |-> !req_ready);
    p_recency_perm_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (r_age_seen == {WAYS{1'b1}}));
    p_valid_has_owner_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> r_owned_ok);
endmodule

// File: tb/test_snoop_filter.sv
`timescale 1ns/1ps
module test_snoop_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_node = '0;
    logic [11:0] req_line = '0;
    logic        req_ready;
    logic [3:0]  snoop_mask;
    logic        evn_valid = 1'b0;
    logic [1:0]  evn_node = '0;
    logic [11:0] evn_line = '0;
    logic        binv_valid;
    logic [11:0] binv_line;
    logic [3:0]  binv_mask;
    logic        binv_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    snoop_filter i_snoop_filter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_node(req_node),
        .req_write(req_write), .req_line(req_line), .req_ready(req_ready),
        .snoop_mask(snoop_mask), .evn_valid(evn_valid), .evn_node(evn_node),
        .evn_line(evn_line), .binv_valid(binv_valid), .binv_line(binv_line),
        .binv_mask(binv_mask), .binv_ack(binv_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // plain request, no back-invalidate expected
    task automatic req(input string tag, input logic [1:0] n, input logic wr,
                       input logic [11:0] line, input logic [3:0] exp_mask);
        @(negedge clk);
        req_valid = 1'b1; req_node = n; req_write = wr; req_line = line;
        #1;
        chk({tag, " mask"}, 32'(snoop_mask), 32'(exp_mask));
        chk({tag, " no binv"}, 32'(binv_valid), 32'd0);
        chk({tag, " ready"}, 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // request expected to need a victim; ack held off one cycle
    task automatic req_victim(input string tag, input logic [1:0] n, input logic [11:0] line,
                              input logic [11:0] exp_bline, input logic [3:0] exp_bmask);
        @(negedge clk);
        req_valid = 1'b1; req_node = n; req_write = 1'b0; req_line = line;
        #1;
        chk({tag, " binv"}, 32'(binv_valid), 32'd1);
        chk({tag, " binv line"}, 32'(binv_line), 32'(exp_bline));
        chk({tag, " binv mask"}, 32'(binv_mask), 32'(exp_bmask));
        chk("R7 stall", 32'(req_ready), 32'd0);
        @(negedge clk); #1;
        chk("R7 still stalled", 32'(req_ready), 32'd0);
        chk("R7 victim held", 32'(binv_line), 32'(exp_bline));
        binv_ack = 1'b1; #1;
        chk("R7 ready on ack", 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        req_valid = 1'b0; binv_ack = 1'b0;
    endtask

    task automatic evn(input logic [1:0] n, input logic [11:0] line);
        @(negedge clk);
        evn_valid = 1'b1; evn_node = n; evn_line = line;
        @(posedge clk); #1;
        evn_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 binv idle", 32'(binv_valid), 32'd0);
        req("R1 first read", 2'd0, 1'b0, 12'h011, 4'b0000);
    endtask

    task automatic t_share_write;
        req("R2 second reader", 2'd1, 1'b0, 12'h011, 4'b0001);
        req("R2 third reader", 2'd2, 1'b0, 12'h011, 4'b0011);
        req("R3 write targets", 2'd3, 1'b0 | 1'b1, 12'h011, 4'b0111);
        req("R3 writer sole owner", 2'd0, 1'b0, 12'h011, 4'b1000);
        req("R3 write miss", 2'd1, 1'b1, 12'h0A1, 4'b0000);
    endtask

    task automatic t_victim;
        // set 5: 015 {0,1}, 025 {0}, 035 {0,1}, 045 {2}; recency 015 oldest
        req("R4 fill a", 2'd0, 1'b0, 12'h015, 4'b0000);
        req("R4 fill a2", 2'd1, 1'b0, 12'h015, 4'b0001);
        req("R4 fill b", 2'd0, 1'b0, 12'h025, 4'b0000);
        req("R4 fill c", 2'd0, 1'b0, 12'h035, 4'b0000);
        req("R4 fill c2", 2'd1, 1'b0, 12'h035, 4'b0001);
        req("R4 fill d", 2'd2, 1'b0, 12'h045, 4'b0000);
        // fewest owners tie 025/045, 025 older -> R5 R6
        req_victim("R5 R6 victim", 2'd3, 12'h055, 12'h025, 4'b0001);
        req("R7 installed", 2'd0, 1'b0, 12'h055, 4'b1000);
    endtask

    task automatic t_recency;
        req("R9 fill a", 2'd0, 1'b0, 12'h016, 4'b0000);
        req("R9 fill b", 2'd1, 1'b0, 12'h026, 4'b0000);
        req("R9 fill c", 2'd2, 1'b0, 12'h036, 4'b0000);
        req("R9 fill d", 2'd3, 1'b0, 12'h046, 4'b0000);
        req("R9 touch oldest", 2'd0, 1'b0, 12'h016, 4'b0000);
        req_victim("R9 next oldest victim", 2'd0, 12'h056, 12'h026, 4'b0010);
    endtask

    task automatic t_evict;
        evn(2'd1, 12'h035);
        req("R8 bit cleared", 2'd2, 1'b0, 12'h035, 4'b0001);
        evn(2'd2, 12'h045);
        req("R8 freed way reused", 2'd0, 1'b0, 12'h065, 4'b0000);
    endtask

    task automatic t_priority;
        req("R10 setup", 2'd0, 1'b0, 12'h017, 4'b0000);
        @(negedge clk);
        evn_valid = 1'b1; evn_node = 2'd0; evn_line = 12'h017;
        req_valid = 1'b1; req_node = 2'd1; req_write = 1'b0; req_line = 12'h017;
        #1;
        chk("R10 request held", 32'(req_ready), 32'd0);
        @(posedge clk); #1;
        evn_valid = 1'b0; #1;
        chk("R10 sees cleared entry", 32'(snoop_mask), 32'd0);
        chk("R10 accepted after", 32'(req_ready), 32'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_share_write();
        t_victim();
        t_recency();
        t_evict();
        t_priority();
        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule